// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask Block

This block collects event strobes from an HDLC controller into an eight-bit sticky interrupt status register. It drives one active-high, level-type interrupt request through an eight-bit enable mask whose bits line up with the status bits. A masked event is still recorded in status, but it cannot raise the request. The driver reads the status register to learn which events occurred, and that read clears them.

Bit 2 of status is shared between two sources. A select bit in the control register decides whether that bit reports transmit FIFO underrun or frame abort. The source that is not selected is dropped.

A small processor port gives access to the registers. It has a chip select, a write enable, a read strobe, a two-bit address and eight-bit data buses. Read data is registered and appears one cycle after the strobe.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: A one-cycle strobe on an event input sets its status bit at the next clock edge. The bit positions are: 7 good address, 6 end-of-packet detect, 5 transmit end-of-packet, 4 end-of-packet received, 3 transmit FIFO low, 2 shared, 1 receive FIFO full, 0 receive overflow.
- R2: A set status bit stays set until the status register is read.
- R3: A read of address 0 returns the status value and clears every bit that was set at that moment. An event arriving in the same cycle as that read is kept set.
- R4: After reset, the mask is 0x00, the control register is 0x00, rdata_o is 0x00 and irq_o is low.
- R5: irq_o is high exactly when some status bit and its mask bit are both 1. An event whose mask bit is 0 still sets status but leaves irq_o low.
- R6: With control bit 0 (the select bit) at 1, bit 2 of status is set by transmit underrun and frame abort is ignored. With the select bit at 0, bit 2 is set by frame abort and underrun is ignored.
- R7: A write to address 1 loads the mask. A read of address 1 returns the mask. A write to address 2 loads the select bit from wdata_i[0]. A read of address 2 returns {7'b0, select}.
- R8: rdata_o updates one cycle after a read strobe and otherwise holds its value. Reads of address 3 return 0x00. Writes to address 0 or address 3 change nothing.
- R9: With cs_i low, read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for the processor port |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| evt_good_addr_i | input | 1 | Good address strobe |
| evt_eop_det_i | input | 1 | End-of-packet detect strobe |
| evt_tx_eop_i | input | 1 | Transmit end-of-packet strobe |
| evt_eop_rx_i | input | 1 | End-of-packet received strobe |
| evt_tx_low_i | input | 1 | Transmit FIFO low strobe |
| evt_abort_i | input | 1 | Frame abort strobe |
| evt_tx_under_i | input | 1 | Transmit FIFO underrun strobe |
| evt_rx_full_i | input | 1 | Receive FIFO full strobe |
| evt_rx_ovfl_i | input | 1 | Receive overflow strobe |
| irq_o | output | 1 | Interrupt request, active high, level |

## Verification
The bench builds the block with its package defaults: an eight-bit register width, a two-bit address and the shared source at bit 2. This keeps the whole status and mask space small. Random mask values, sparse random events and frequent reads therefore reach every pairing of a set bit with an enabled or disabled mask bit. They also reach reads that collide with new events and select-bit flips while either shared source is active.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int SHARED_B = 2;
  localparam int SEL_B    = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_CTRL   = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic good_addr;
    logic eop_det;
    logic tx_eop;
    logic eop_rx;
    logic tx_low;
    logic abort;
    logic tx_under;
    logic rx_full;
    logic rx_ovfl;
  } evt_t;
endpackage

// File: rtl/hdlc_irq_evt_map.sv
module hdlc_irq_evt_map
  import hdlc_irq_pkg::*;
(
  input  evt_t             evt_i,
  input  logic             sel_i,
  output logic [REG_W-1:0] vec_o
);
  always_comb begin
    vec_o           = '0;
    vec_o[7]        = evt_i.good_addr;
    vec_o[6]        = evt_i.eop_det;
    vec_o[5]        = evt_i.tx_eop;
    vec_o[4]        = evt_i.eop_rx;
    vec_o[3]        = evt_i.tx_low;
    vec_o[SHARED_B] = sel_i ? evt_i.tx_under : evt_i.abort;
    vec_o[1]        = evt_i.rx_full;
    vec_o[0]        = evt_i.rx_ovfl;
  end
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
  import hdlc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] status_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_o[b] <= 1'b0;
      else if (set_i[b]) status_o[b] <= 1'b1;  // new event wins over clear
      else if (clr_i)    status_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
  import hdlc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  mask_o,
  output logic              sel_o,
  output logic              rd_clr_o
);
  reg_addr_e        addr;
  logic             wr_en, rd_en;
  logic [REG_W-1:0] rd_mux;

  assign addr     = reg_addr_e'(addr_i);
  assign wr_en    = cs_i && we_i;
  assign rd_en    = cs_i && rd_i;
  assign rd_clr_o = rd_en && (addr == A_STATUS);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STATUS: rd_mux = status_i;
      A_MASK:   rd_mux = mask_o;
      A_CTRL:   rd_mux[SEL_B] = sel_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      sel_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (wr_en && addr == A_MASK) mask_o <= wdata_i;
      if (wr_en && addr == A_CTRL) sel_o  <= wdata_i[SEL_B];
      if (rd_en)                   rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
  import hdlc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              evt_good_addr_i,
  input  logic              evt_eop_det_i,
  input  logic              evt_tx_eop_i,
  input  logic              evt_eop_rx_i,
  input  logic              evt_tx_low_i,
  input  logic              evt_abort_i,
  input  logic              evt_tx_under_i,
  input  logic              evt_rx_full_i,
  input  logic              evt_rx_ovfl_i,
  output logic              irq_o
);
  evt_t             evt;
  logic [REG_W-1:0] set_vec, status_q, mask_q;
  logic             sel_q, rd_clr;

  assign evt = '{good_addr: evt_good_addr_i, eop_det: evt_eop_det_i,
                 tx_eop: evt_tx_eop_i, eop_rx: evt_eop_rx_i,
                 tx_low: evt_tx_low_i, abort: evt_abort_i,
                 tx_under: evt_tx_under_i, rx_full: evt_rx_full_i,
                 rx_ovfl: evt_rx_ovfl_i};

  hdlc_irq_evt_map u_map (
    .evt_i (evt),
    .sel_i (sel_q),
    .vec_o (set_vec)
  );

  hdlc_irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (rd_clr),
    .status_o (status_q)
  );

  hdlc_irq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .we_i     (we_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status_q),
    .rdata_o  (rdata_o),
    .mask_o   (mask_q),
    .sel_o    (sel_q),
    .rd_clr_o (rd_clr)
  );

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/hdlc_irq_ctrl_chk.sv
module hdlc_irq_ctrl_chk
  import hdlc_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              evt_good_addr_i,
  input logic              evt_abort_i,
  input logic              evt_tx_under_i,
  input logic              evt_rx_ovfl_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  mask_q,
  input logic              sel_q
);
  AST_EVT_OVFL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_ovfl_i |=> status_q[0]);  // R1
  AST_EVT_GADDR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_good_addr_i |=> status_q[7]);  // R1
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i && addr_i == 2'd0) |=>
      ((status_q & $past(status_q)) == $past(status_q)));  // R2
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == 2'd0 && !evt_rx_ovfl_i) |=> !status_q[0]);  // R3
  AST_NO_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);  // R5
  AST_SEL_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && evt_abort_i) |=> status_q[2]);  // R6
  AST_SEL_UNDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && evt_tx_under_i) |=> status_q[2]);  // R6
  AST_UNSEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_q[2] && sel_q && !evt_tx_under_i) |=> !status_q[2]);  // R6
  AST_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == 2'd1) |=> (rdata_o == $past(mask_q)));  // R7
endmodule

bind hdlc_irq_ctrl hdlc_irq_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cs_i            (cs_i),
  .rd_i            (rd_i),
  .addr_i          (addr_i),
  .rdata_o         (rdata_o),
  .evt_good_addr_i (evt_good_addr_i),
  .evt_abort_i     (evt_abort_i),
  .evt_tx_under_i  (evt_tx_under_i),
  .evt_rx_ovfl_i   (evt_rx_ovfl_i),
  .irq_o           (irq_o),
  .status_q        (status_q),
  .mask_q          (mask_q),
  .sel_q           (sel_q)
);

// File: tb/hdlc_irq_ctrl_bench.sv
module hdlc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, we = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [8:0] ev = 0;  // {gaddr,eopdet,txeop,eoprx,txlow,abort,under,rxfull,ovfl}
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_status = 0, m_mask = 0, m_rdata = 0;
  logic       m_sel = 0;

  always #2.5 clk = ~clk;

  hdlc_irq_ctrl u_hdlc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .evt_good_addr_i(ev[8]), .evt_eop_det_i(ev[7]), .evt_tx_eop_i(ev[6]),
    .evt_eop_rx_i(ev[5]), .evt_tx_low_i(ev[4]), .evt_abort_i(ev[3]),
    .evt_tx_under_i(ev[2]), .evt_rx_full_i(ev[1]), .evt_rx_ovfl_i(ev[0]),
    .irq_o(irq)
  );

  function automatic logic [7:0] map_ev(logic [8:0] e, logic s);
    return {e[8], e[7], e[6], e[5], e[4], (s ? e[2] : e[3]), e[1], e[0]};
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [8:0] e, logic c, logic w, logic r,
                      logic [1:0] a, logic [7:0] d);
    logic [7:0] nxt_status;
    ev = e; cs = c; we = w; rd = r; addr = a; wdata = d;
    nxt_status = map_ev(e, m_sel) | ((c && r && a == 2'd0) ? 8'h00 : m_status);
    if (c && r)
      case (a)
        2'd0: m_rdata = m_status;
        2'd1: m_rdata = m_mask;
        2'd2: m_rdata = {7'b0, m_sel};
        default: m_rdata = 8'h00;
      endcase
    if (c && w && a == 2'd1) m_mask = d;
    if (c && w && a == 2'd2) m_sel = d[0];
    m_status = nxt_status;
    @(negedge clk);
    check(tag, "irq_o", {7'b0, irq}, {7'b0, |(m_status & m_mask)});
    check(tag, "rdata_o", rdata, m_rdata);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R4", "rdata_o reset", rdata, 8'h00);
    check("R4", "irq_o reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step("R4", 9'h0, 1, 0, 1, 2'd1, 8'h0);            // mask reads 0
    step("R4", 9'h0, 1, 0, 1, 2'd2, 8'h0);            // ctrl reads 0
    // masked event recorded, no irq
    step("R5", 9'h100, 0, 0, 0, 2'd0, 8'h0);
    step("R1", 9'h0, 1, 0, 1, 2'd0, 8'h0);            // read 0x80
    check("R1", "gaddr bit", rdata, 8'h80);
    step("R3", 9'h0, 1, 0, 1, 2'd0, 8'h0);            // now cleared
    check("R3", "cleared", rdata, 8'h00);
    step("R7", 9'h0, 1, 1, 0, 2'd1, 8'hFF);
    step("R7", 9'h0, 1, 0, 1, 2'd1, 8'h0);
    check("R7", "mask readback", rdata, 8'hFF);
    // select 0: underrun ignored, abort sets bit 2
    step("R6", 9'h004, 0, 0, 0, 2'd0, 8'h0);
    step("R6", 9'h0, 1, 0, 1, 2'd0, 8'h0);
    check("R6", "underrun ignored", rdata, 8'h00);
    step("R6", 9'h008, 0, 0, 0, 2'd0, 8'h0);
    check("R6", "abort irq", {7'b0, irq}, 8'h01);
    repeat (4) step("R2", 9'h0, 0, 0, 0, 2'd0, 8'h0);
    check("R2", "sticky irq", {7'b0, irq}, 8'h01);
    // read collides with new overflow event
    step("R3", 9'h001, 1, 0, 1, 2'd0, 8'h0);
    check("R3", "read value", rdata, 8'h04);
    step("R3", 9'h0, 1, 0, 1, 2'd0, 8'h0);
    check("R3", "kept event", rdata, 8'h01);
    // cs low: no write
    step("R9", 9'h0, 0, 1, 0, 2'd1, 8'h00);
    step("R9", 9'h0, 1, 0, 1, 2'd1, 8'h0);
    check("R9", "mask unchanged", rdata, 8'hFF);
    step("R9", 9'h0, 0, 0, 1, 2'd0, 8'h0);
    check("R9", "rdata held", rdata, 8'hFF);
    // writes to status and addr 3 ignored, addr 3 reads 0
    step("R8", 9'h0, 1, 1, 0, 2'd0, 8'hFF);
    step("R8", 9'h0, 1, 1, 0, 2'd3, 8'hFF);
    step("R8", 9'h0, 1, 0, 1, 2'd3, 8'h0);
    check("R8", "addr3 read", rdata, 8'h00);
    step("R8", 9'h0, 1, 0, 1, 2'd0, 8'h0);
    check("R8", "status after writes", rdata, 8'h00);
    // select 1: underrun sets bit 2, abort ignored
    step("R6", 9'h0, 1, 1, 0, 2'd2, 8'h01);
    step("R6", 9'h008, 0, 0, 0, 2'd0, 8'h0);
    step("R6", 9'h004, 1, 0, 1, 2'd0, 8'h0);
    check("R6", "abort ignored", rdata, 8'h00);
    step("R6", 9'h0, 1, 0, 1, 2'd0, 8'h0);
    check("R6", "underrun seen", rdata, 8'h04);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [8:0] e;
      logic [1:0] a;
      logic c, w, r;
      e = 9'h0;
      for (int k = 0; k < 9; k++) e[k] = ($urandom % 12) == 0;
      a = 2'($urandom % 4);
      c = ($urandom % 4) != 0;
      w = ($urandom % 5) == 0;
      r = ($urandom % 3) == 0;
      step(r && a == 2'd0 ? "R3" : (a == 2'd1 ? "R7" : "R5"),
           e, c, w, r, a, 8'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule